// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Latches

This block keeps wall-clock time and date in packed BCD. It holds seconds, minutes, hours, day of month, month and a two-digit year, plus a day-of-week counter. It advances once for each one-cycle pulse on its tick input, but only while the run bit in its control byte is set. Software reaches every field through a byte-wide register port. Writes take effect at the clock edge, and reads are combinational from the address.

A multi-byte read of a moving clock can tear, for example when the minutes are read just before a seconds carry. To avoid this, software writes the capture bit of the control byte from 0 to 1. That copies all seven live counters into static shadow latches in one cycle. With the shadow-select bit set, reads of the time offsets return the frozen copy. To set the time, software stops the clock, writes the fields and starts it again. Hours count either 00..23 or 01..12 with a PM flag. Two compensation bytes are held for software, and the block does not act on them.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the time fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00. The control byte (offset 0x0D) and the status byte (offset 0x0E) read 0x00.
- R2: A tick advances seconds by one in BCD only while control bit 0 is 1. Ticks have no effect while it is 0. Status bit 1 reads the value of control bit 0.
- R3: Seconds roll from 0x59 to 0x00 and carry one into minutes. Minutes roll from 0x59 to 0x00 and carry one into hours. The time offsets are 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year and 0x06 weekday.
- R4: With control bit 3 at 0 (24-hour), hours roll from 0x23 to 0x00 and advance the day. On that day step the weekday counts 0..6 and wraps from 6 to 0.
- R5: The day wraps to 0x01 after the last day of its month: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the BCD year is a multiple of 4 (00 included) and 28 days otherwise. Month 0x12 wraps to 0x01 and carries into the year, and year 0x99 wraps to 0x00.
- R6: With control bit 3 at 1 (12-hour), the hours byte holds 0x01..0x12 in bits 6:0 and the PM flag in bit 7. 11 rolls to 12 and toggles PM, 12 rolls to 01 with PM unchanged, and 11 PM rolls to 12 AM and advances the day.
- R7: Writes to offsets 0x00..0x06 load the field only while control bit 0 is 0. While it is 1 they are ignored.
- R8: A control write that takes bit 6 from 0 to 1 copies all seven live fields into the shadow latches. Bit 6 reads back as written, and a write that leaves it at 1 takes no new copy.
- R9: With control bit 7 at 1, reads of offsets 0x00..0x06 return the shadow copy. With it at 0 they return the live counters.
- R10: The whole control byte reads back as written; bits 1 and 2 (round and auto-compensate) are stored only. Offsets 0x10 and 0x11 are read/write storage. The status byte ignores writes, and unmapped offsets read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |

## Verification
The hardest state to reach from the ports is a full cascade in which one tick ripples from seconds through to the year. The same kind of cascade arises at the leap-dependent end of February. Waiting for such a cascade by ticking from reset would take millions of ticks. The bench therefore stops the clock, loads the field values one tick before the boundary, restarts, and issues a single tick. Snapshot coherence is shown by capturing, ticking the live counters onward, and then reading the frozen copy. After that the bench holds the capture bit high across a second control write to prove that no re-capture occurs.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_FIELDS = 7;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_DAY  = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YEAR = 5;
  localparam int unsigned F_WDAY = 6;

  localparam int unsigned A_CTRL    = 'h0D;
  localparam int unsigned A_STATUS  = 'h0E;
  localparam int unsigned A_COMP_LO = 'h10;
  localparam int unsigned A_COMP_HI = 'h11;

  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_MODE12  = 3;
  localparam int unsigned CB_CAPTURE = 6;
  localparam int unsigned CB_SHADOW  = 7;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [N_FIELDS-1:0][BYTE_W-1:0] fields_t;

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (2*tens + ones) mod 4 == 0
  function automatic logic bcd_leap(byte_t y);
    return y[4] ? (y[1:0] == 2'd2) : (y[1:0] == 2'd0);
  endfunction

  function automatic byte_t month_last(byte_t m, logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  byte_t hour_i,
  input  logic  mode12_i,
  output byte_t hour_o,
  output logic  day_o
);
  byte_t h12;
  assign h12 = {1'b0, hour_i[6:0]};

  always_comb begin
    day_o  = 1'b0;
    hour_o = bcd_inc(hour_i);
    if (mode12_i) begin
      if (h12 == 8'h12) begin
        hour_o = {hour_i[7], 7'h01};
      end else if (h12 == 8'h11) begin
        hour_o = {~hour_i[7], 7'h12};
        day_o  = hour_i[7];
      end else begin
        hour_o = bcd_inc(h12) | {hour_i[7], 7'h00};
      end
    end else if (hour_i >= 8'h23) begin
      hour_o = 8'h00;
      day_o  = 1'b1;
    end
  end
endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
  import cal_pkg::*;
(
  input  byte_t day_i,
  input  byte_t mon_i,
  input  byte_t year_i,
  output byte_t day_o,
  output byte_t mon_o,
  output byte_t year_o
);
  byte_t last;
  assign last = month_last(mon_i, bcd_leap(year_i));

  always_comb begin
    day_o  = bcd_inc(day_i);
    mon_o  = mon_i;
    year_o = year_i;
    if (day_i >= last) begin
      day_o = 8'h01;
      if (mon_i >= 8'h12) begin
        mon_o  = 8'h01;
        year_o = (year_i >= 8'h99) ? 8'h00 : bcd_inc(year_i);
      end else begin
        mon_o = bcd_inc(mon_i);
      end
    end
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                mode12_i,
  input  logic [N_FIELDS-1:0] wsel_i,
  input  byte_t               wdata_i,
  output fields_t             time_o
);
  localparam fields_t RST_TIME = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  fields_t time_q, adv, nxt;
  byte_t   hour_n, day_n, mon_n, year_n;
  logic    day_carry;

  cal_hour_step hour_step_i (
    .hour_i  (time_q[F_HOUR]),
    .mode12_i(mode12_i),
    .hour_o  (hour_n),
    .day_o   (day_carry)
  );

  cal_date_step date_step_i (
    .day_i (time_q[F_DAY]),
    .mon_i (time_q[F_MON]),
    .year_i(time_q[F_YEAR]),
    .day_o (day_n),
    .mon_o (mon_n),
    .year_o(year_n)
  );

  logic sec_wrap, min_wrap;
  assign sec_wrap = time_q[F_SEC] >= 8'h59;
  assign min_wrap = time_q[F_MIN] >= 8'h59;

  always_comb begin
    adv = time_q;
    if (step_i) begin
      adv[F_SEC] = sec_wrap ? 8'h00 : bcd_inc(time_q[F_SEC]);
      if (sec_wrap) begin
        adv[F_MIN] = min_wrap ? 8'h00 : bcd_inc(time_q[F_MIN]);
        if (min_wrap) begin
          adv[F_HOUR] = hour_n;
          if (day_carry) begin
            adv[F_DAY]  = day_n;
            adv[F_MON]  = mon_n;
            adv[F_YEAR] = year_n;
            adv[F_WDAY] = (time_q[F_WDAY] >= 8'h06) ? 8'h00 : time_q[F_WDAY] + 8'h01;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_lane
    assign nxt[g] = wsel_i[g] ? wdata_i : adv[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= RST_TIME;
    else         time_q <= nxt;
  end

  assign time_o = time_q;
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  byte_t   ctrl_q, comp_lo_q, comp_hi_q;
  fields_t shadow_q, live_time;
  logic    run, cap_pulse, hit_ctrl;
  logic [N_FIELDS-1:0] wsel;

  assign run       = ctrl_q[CB_RUN];
  assign hit_ctrl  = wr_i && (addr_i == ADDR_W'(A_CTRL));
  assign cap_pulse = hit_ctrl && wdata_i[CB_CAPTURE] && !ctrl_q[CB_CAPTURE];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_wsel
    assign wsel[g] = wr_i && !run && (addr_i == ADDR_W'(g));
  end

  cal_time_core core_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tick_i && run),
    .mode12_i(ctrl_q[CB_MODE12]),
    .wsel_i  (wsel),
    .wdata_i (wdata_i),
    .time_o  (live_time)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      comp_lo_q <= '0;
      comp_hi_q <= '0;
      shadow_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= wdata_i;
      if (wr_i && addr_i == ADDR_W'(A_COMP_LO)) comp_lo_q <= wdata_i;
      if (wr_i && addr_i == ADDR_W'(A_COMP_HI)) comp_hi_q <= wdata_i;
      if (cap_pulse) shadow_q <= live_time;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = ctrl_q[CB_SHADOW] ? shadow_q[i] : live_time[i];
    end
    if (addr_i == ADDR_W'(A_CTRL))    rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(A_STATUS))  rdata_o = {6'b0, run, 1'b0};
    if (addr_i == ADDR_W'(A_COMP_LO)) rdata_o = comp_lo_q;
    if (addr_i == ADDR_W'(A_COMP_HI)) rdata_o = comp_hi_q;
  end
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wcap_i,
  input logic              rd_run_i,
  input logic              run_i,
  input logic              mode12_i,
  input logic              cap_i,
  input fields_t           live_i,
  input fields_t           shadow_i
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (addr_i == ADDR_W'(A_CTRL));

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !wr_i |=> $stable(live_i)); // R2
  AST_STATUS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(A_STATUS) |-> rd_run_i == run_i); // R2
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !wr_i && live_i[F_SEC] == 8'h59
    |=> live_i[F_SEC] == 8'h00 && live_i[F_MIN] != $past(live_i[F_MIN])); // R3
  AST_HOUR24_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !wr_i && !mode12_i && live_i[F_HOUR] == 8'h23
    && live_i[F_MIN] == 8'h59 && live_i[F_SEC] == 8'h59 |=> live_i[F_HOUR] == 8'h00); // R4
  AST_HOUR12_NOON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !wr_i && mode12_i && live_i[F_HOUR] == 8'h11
    && live_i[F_MIN] == 8'h59 && live_i[F_SEC] == 8'h59 |=> live_i[F_HOUR] == 8'h92); // R6
  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i && !ctrl_wr |=> $stable(live_i)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr && wcap_i && !cap_i) |=> $stable(shadow_i)); // R8
endmodule

bind bcd_cal_clock cal_clock_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wcap_i  (wdata_i[6]),
  .rd_run_i(rdata_o[1]),
  .run_i   (ctrl_q[0]),
  .mode12_i(ctrl_q[3]),
  .cap_i   (ctrl_q[6]),
  .live_i  (live_time),
  .shadow_i(shadow_q)
);

// File: tb/bcd_cal_clock_tb_top.sv
module bcd_cal_clock_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_cal_clock #(.ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, $sformatf("reg %02h", a), rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] mode, input logic [7:0] s, m, h, d, mo, y, w);
    wr_reg(5'h0D, mode);
    wr_reg(5'h00, s); wr_reg(5'h01, m); wr_reg(5'h02, h); wr_reg(5'h03, d);
    wr_reg(5'h04, mo); wr_reg(5'h05, y); wr_reg(5'h06, w);
    wr_reg(5'h0D, mode | 8'h01);
  endtask

  task automatic t_reset;
    rd_chk("R1", 5'h00, 8'h00); rd_chk("R1", 5'h01, 8'h00); rd_chk("R1", 5'h02, 8'h00);
    rd_chk("R1", 5'h03, 8'h01); rd_chk("R1", 5'h04, 8'h01); rd_chk("R1", 5'h05, 8'h00);
    rd_chk("R1", 5'h06, 8'h00); rd_chk("R1", 5'h0D, 8'h00); rd_chk("R1", 5'h0E, 8'h00);
  endtask

  task automatic t_run_stop;
    ticks(2);
    rd_chk("R2", 5'h00, 8'h00);
    wr_reg(5'h0D, 8'h01);
    rd_chk("R2", 5'h0E, 8'h02);
    ticks(1);
    rd_chk("R2", 5'h00, 8'h01);
    ticks(9);
    rd_chk("R2", 5'h00, 8'h10);
    wr_reg(5'h0D, 8'h00);
    rd_chk("R2", 5'h0E, 8'h00);
    ticks(3);
    rd_chk("R2", 5'h00, 8'h10);
  endtask

  task automatic t_write_guard;
    wr_reg(5'h0D, 8'h01);
    wr_reg(5'h00, 8'h45);
    rd_chk("R7", 5'h00, 8'h10);
    wr_reg(5'h0D, 8'h00);
    wr_reg(5'h00, 8'h45);
    rd_chk("R7", 5'h00, 8'h45);
  endtask

  task automatic t_sec_min;
    set_time(8'h00, 8'h59, 8'h59, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    ticks(1);
    rd_chk("R3", 5'h00, 8'h00); rd_chk("R3", 5'h01, 8'h00); rd_chk("R3", 5'h02, 8'h01);
    set_time(8'h00, 8'h59, 8'h09, 8'h05, 8'h01, 8'h01, 8'h00, 8'h00);
    ticks(1);
    rd_chk("R3", 5'h01, 8'h10);
  endtask

  task automatic t_day;
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h05, 8'h03, 8'h20, 8'h06);
    ticks(1);
    rd_chk("R4", 5'h02, 8'h00); rd_chk("R4", 5'h03, 8'h06); rd_chk("R4", 5'h06, 8'h00);
  endtask

  task automatic t_month;
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h21, 8'h01);
    ticks(1);
    rd_chk("R5", 5'h03, 8'h01); rd_chk("R5", 5'h04, 8'h05); rd_chk("R5", 5'h06, 8'h02);
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h21, 8'h01);
    ticks(1);
    rd_chk("R5", 5'h03, 8'h31);
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h01);
    ticks(1);
    rd_chk("R5", 5'h03, 8'h01); rd_chk("R5", 5'h04, 8'h03);
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h01);
    ticks(1);
    rd_chk("R5", 5'h03, 8'h29); rd_chk("R5", 5'h04, 8'h02);
    ticks(86400 - 1);
    ticks(1);
    rd_chk("R5", 5'h03, 8'h01); rd_chk("R5", 5'h04, 8'h03);
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h10, 8'h01);
    ticks(1);
    rd_chk("R5", 5'h03, 8'h01);
    set_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h03);
    ticks(1);
    rd_chk("R5", 5'h00, 8'h00); rd_chk("R5", 5'h02, 8'h00); rd_chk("R5", 5'h03, 8'h01);
    rd_chk("R5", 5'h04, 8'h01); rd_chk("R5", 5'h05, 8'h00);
  endtask

  task automatic t_12h;
    set_time(8'h08, 8'h59, 8'h59, 8'h11, 8'h10, 8'h07, 8'h22, 8'h00);
    ticks(1);
    rd_chk("R6", 5'h02, 8'h92);
    set_time(8'h08, 8'h59, 8'h59, 8'h92, 8'h10, 8'h07, 8'h22, 8'h00);
    ticks(1);
    rd_chk("R6", 5'h02, 8'h81);
    set_time(8'h08, 8'h59, 8'h59, 8'h91, 8'h10, 8'h07, 8'h22, 8'h00);
    ticks(1);
    rd_chk("R6", 5'h02, 8'h12); rd_chk("R6", 5'h03, 8'h11);
    set_time(8'h08, 8'h59, 8'h59, 8'h09, 8'h10, 8'h07, 8'h22, 8'h00);
    ticks(1);
    rd_chk("R6", 5'h02, 8'h10);
  endtask

  task automatic t_capture;
    set_time(8'h00, 8'h20, 8'h30, 8'h08, 8'h15, 8'h06, 8'h25, 8'h02);
    wr_reg(5'h0D, 8'h41);
    ticks(3);
    wr_reg(5'h0D, 8'hC1);
    rd_chk("R8", 5'h0D, 8'hC1);
    rd_chk("R9", 5'h00, 8'h20);
    rd_chk("R9", 5'h01, 8'h30);
    wr_reg(5'h0D, 8'h41);
    rd_chk("R9", 5'h00, 8'h23);
    wr_reg(5'h0D, 8'h01);
    wr_reg(5'h0D, 8'hC1);
    ticks(1);
    rd_chk("R8", 5'h00, 8'h23);
    wr_reg(5'h0D, 8'h01);
    rd_chk("R9", 5'h00, 8'h24);
  endtask

  task automatic t_misc;
    wr_reg(5'h0D, 8'h36);
    rd_chk("R10", 5'h0D, 8'h36);
    wr_reg(5'h10, 8'hA5);
    wr_reg(5'h11, 8'h3C);
    rd_chk("R10", 5'h10, 8'hA5);
    rd_chk("R10", 5'h11, 8'h3C);
    wr_reg(5'h0E, 8'hFF);
    rd_chk("R10", 5'h0E, 8'h00);
    wr_reg(5'h08, 8'h77);
    rd_chk("R10", 5'h08, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run_stop();
    t_write_guard();
    t_sec_min();
    t_day();
    t_month();
    t_12h();
    t_capture();
    t_misc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule